// File: doc/BRIEF.md
# Type-A Card Activation and Select Sequencer

This block runs the reader side of the Type-A card activation handshake over a byte-wide frame interface. A one-cycle `start` makes it send a 7-bit request frame, or a wake-up frame that also reaches halted cards. It checks the two-byte answer and then works through up to three cascade levels. At each level it sends an anticollision frame, checks the returned four UID bytes against their XOR check byte, and then sends the full select frame. From the returned select-acknowledge byte (SAK) it decides whether another level must follow. A cascade-tag byte that opens a non-final level is dropped, so the UID comes out as one contiguous 4-, 7- or 10-byte value. The card can then be sent to the halted state.

Outgoing frames are presented one byte per cycle with a last-byte marker. Each frame also carries the number of valid bits in its final byte and a flag that asks the transmit helper to append a CRC. Incoming bytes arrive from a receive helper with CRC already stripped. That helper also supplies a collision flag and, on the last byte, a CRC verdict. A single one-cycle `done` reports the outcome code. The assembled UID, its length and the last SAK stay on the outputs until the next start.

Top module: `anticoll_select`

## Requirements
- R1: After reset `busy`, `tx_valid` and `done` are low, and `uid`, `uid_len` and `sak` are zero.
- R2: `start` while idle transmits a one-byte frame with `tx_bits`=7 and `tx_crc`=0. The byte is 0x52 when `wakeup` is high and 0x26 when it is low. `start` while `busy` is ignored and begins no frame.
- R3: The answer to the request must be exactly 2 bytes, otherwise the status is ERROR. The collision flag is ignored during this answer.
- R4: Each level n (0, 1, 2) first sends the 2-byte frame {0x93+2n, 0x20} with `tx_bits`=0 and `tx_crc`=0. The answer must be 5 bytes, otherwise ERROR. Any answer byte flagged with `rx_coll` gives COLLISION.
- R5: When the fifth answer byte differs from the XOR of the first four, the status is ERROR.
- R6: The level then sends the 7-byte frame {0x93+2n, 0x70, four UID bytes, check byte} with `tx_crc`=1. The answer must be 1 byte, otherwise ERROR. A low `rx_crc_ok` on it gives CRC_WRONG.
- R7: A SAK with bit 2 set starts the next level. It requires that the first UID byte of the current level is 0x88, otherwise ERROR. A set bit 2 at level 2 is ERROR.
- R8: The UID bytes are packed in arrival order from `uid[7:0]` upward. The 0x88 tag bytes are dropped. A clean finish reports `uid_len` 4, 7 or 10 and presents the final SAK on `sak`.
- R9: With `halt_after` set, a complete select is followed by the frame {0x50, 0x00} with `tx_crc`=1. Silence for the timeout window then gives OK, and any answer gives NAK.
- R10: While waiting for an answer, `TIMEOUT_CYC` consecutive cycles without a received byte end the run with TIMEOUT, except after the halt frame.
- R11: `done` is a one-cycle pulse issued as `busy` falls. Its `status` codes are OK=0, ERROR=1, COLLISION=2, TIMEOUT=3, CRC_WRONG=4, NAK=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an activation run when idle |
| wakeup | input | 1 | Use the wake-up request instead of the plain request |
| halt_after | input | 1 | Halt the card after a successful select |
| busy | output | 1 | A run is in progress |
| tx_valid | output | 1 | Outgoing frame byte present this cycle |
| tx_byte | output | 8 | Outgoing frame byte |
| tx_last | output | 1 | This byte ends the frame |
| tx_bits | output | 3 | Valid bits in the final byte, 0 meaning 8 |
| tx_crc | output | 1 | Ask the transmit helper to append a CRC |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_byte | input | 8 | Received byte, CRC removed |
| rx_last | input | 1 | This byte ends the received frame |
| rx_coll | input | 1 | A bit collision affected this byte |
| rx_crc_ok | input | 1 | CRC verdict, valid with `rx_last` |
| done | output | 1 | One-cycle end-of-run pulse |
| status | output | 3 | Outcome code, see R11 |
| uid | output | 80 | Assembled UID, first byte in bits 7:0 |
| uid_len | output | 4 | UID length in bytes |
| sak | output | 8 | Last select-acknowledge byte |

## Verification
A card that answers at one, two and three levels separates correct cascade-tag stripping and byte packing from off-by-one placement of the second and third groups. Both request variants are used, and a halt with a silent card is contrasted with a halt that draws an answer. Each fault pattern is sent on its own and must yield its own code: a corrupt check byte, a flagged collision, a bad CRC, a missing tag, an over-long answer, silence and a third incomplete SAK. This shows that each check fires in the phase it belongs to. A start pulse during a run and a collision flag on the request answer show that those inputs change nothing.

// File: rtl/anticoll_select.sv
module anticoll_select #(
  parameter int TIMEOUT_CYC = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        wakeup,
  input  logic        halt_after,
  output logic        busy,
  output logic        tx_valid,
  output logic [7:0]  tx_byte,
  output logic        tx_last,
  output logic [2:0]  tx_bits,
  output logic        tx_crc,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        rx_last,
  input  logic        rx_coll,
  input  logic        rx_crc_ok,
  output logic        done,
  output logic [2:0]  status,
  output logic [79:0] uid,
  output logic [3:0]  uid_len,
  output logic [7:0]  sak
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] T_END = TW'(TIMEOUT_CYC - 1);
  localparam logic [2:0] C_OK = 3'd0, C_ERR = 3'd1, C_COLL = 3'd2,
                         C_TMO = 3'd3, C_CRC = 3'd4, C_NAK = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_TX, S_RX, S_EVAL} state_t;
  typedef enum logic [1:0] {P_REQ, P_AC, P_SEL, P_HLT} phase_t;

  state_t      st;
  phase_t      ph, ev_ph;
  logic [2:0]  idx, tx_n, rcnt, ev_code, ev_app;
  logic [1:0]  lvl, ev_lvl;
  logic [7:0]  rbuf [5];
  logic [7:0]  sel_cmd, chk;
  logic [TW-1:0] tmr;
  logic        coll_q, crc_q, wake_q, halt_q, ev_fin, ev_go;

  assign sel_cmd  = 8'h93 + {5'd0, lvl, 1'b0};
  assign chk      = rbuf[0] ^ rbuf[1] ^ rbuf[2] ^ rbuf[3];
  assign busy     = (st != S_IDLE);
  assign tx_valid = (st == S_TX);
  assign tx_last  = tx_valid && (idx == tx_n - 3'd1);
  assign tx_bits  = (ph == P_REQ) ? 3'd7 : 3'd0;
  assign tx_crc   = (ph == P_SEL) || (ph == P_HLT);

  always_comb begin
    case (ph)
      P_REQ:   tx_n = 3'd1;
      P_SEL:   tx_n = 3'd7;
      default: tx_n = 3'd2;
    endcase
  end

  always_comb begin
    case (ph)
      P_REQ: tx_byte = wake_q ? 8'h52 : 8'h26;
      P_AC:  tx_byte = (idx == 3'd0) ? sel_cmd : 8'h20;
      P_HLT: tx_byte = (idx == 3'd0) ? 8'h50 : 8'h00;
      default: begin
        case (idx)
          3'd0:    tx_byte = sel_cmd;
          3'd1:    tx_byte = 8'h70;
          3'd2:    tx_byte = rbuf[0];
          3'd3:    tx_byte = rbuf[1];
          3'd4:    tx_byte = rbuf[2];
          3'd5:    tx_byte = rbuf[3];
          default: tx_byte = rbuf[4];
        endcase
      end
    endcase
  end

  always_comb begin
    ev_fin  = 1'b0;
    ev_go   = 1'b0;
    ev_code = C_OK;
    ev_ph   = ph;
    ev_lvl  = lvl;
    ev_app  = 3'd0;
    case (ph)
      P_REQ: begin
        if (rcnt == 3'd2) begin ev_go = 1'b1; ev_ph = P_AC; end
        else begin ev_fin = 1'b1; ev_code = C_ERR; end
      end
      P_AC: begin
        ev_fin = 1'b1;
        if (coll_q)                ev_code = C_COLL;
        else if (rcnt != 3'd5)     ev_code = C_ERR;
        else if (rbuf[4] != chk)   ev_code = C_ERR;
        else begin ev_fin = 1'b0; ev_go = 1'b1; ev_ph = P_SEL; end
      end
      P_SEL: begin
        if (rcnt != 3'd1) begin ev_fin = 1'b1; ev_code = C_ERR; end
        else if (!crc_q) begin ev_fin = 1'b1; ev_code = C_CRC; end
        else if (sak[2]) begin
          if (lvl == 2'd2 || rbuf[0] != 8'h88) begin
            ev_fin = 1'b1; ev_code = C_ERR;
          end else begin
            ev_app = 3'd3; ev_go = 1'b1; ev_ph = P_AC; ev_lvl = lvl + 2'd1;
          end
        end else begin
          ev_app = 3'd4;
          if (halt_q) begin ev_go = 1'b1; ev_ph = P_HLT; end
          else ev_fin = 1'b1;
        end
      end
      default: begin ev_fin = 1'b1; ev_code = C_NAK; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= P_REQ; idx <= '0; rcnt <= '0; lvl <= '0; tmr <= '0;
      coll_q <= 1'b0; crc_q <= 1'b0; wake_q <= 1'b0; halt_q <= 1'b0;
      done <= 1'b0; status <= C_OK; uid <= '0; uid_len <= '0; sak <= '0;
      for (int k = 0; k < 5; k++) rbuf[k] <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_TX; ph <= P_REQ; idx <= '0; lvl <= '0;
          wake_q <= wakeup; halt_q <= halt_after;
          uid <= '0; uid_len <= '0; sak <= '0;
        end
        S_TX: begin
          if (tx_last) begin
            st <= S_RX; rcnt <= '0; coll_q <= 1'b0; crc_q <= 1'b0; tmr <= '0;
          end else idx <= idx + 3'd1;
        end
        S_RX: begin
          if (rx_valid) begin
            tmr <= '0;
            if (ph == P_SEL) begin
              if (rcnt == 3'd0) sak <= rx_byte;
            end else if (rcnt < 3'd5) rbuf[rcnt] <= rx_byte;
            if (rcnt != 3'd7) rcnt <= rcnt + 3'd1;
            if (ph != P_REQ) coll_q <= coll_q | rx_coll;
            if (rx_last) begin crc_q <= rx_crc_ok; st <= S_EVAL; end
          end else if (tmr == T_END) begin
            st <= S_IDLE; done <= 1'b1;
            status <= (ph == P_HLT) ? C_OK : C_TMO;
          end else tmr <= tmr + 1'b1;
        end
        default: begin
          for (int k = 0; k < 10; k++)
            if (k >= int'(uid_len) && k < int'(uid_len) + int'(ev_app))
              uid[8*k +: 8] <= rbuf[(k - int'(uid_len) + ((ev_app == 3'd3) ? 1 : 0)) % 5];
          uid_len <= uid_len + {1'b0, ev_app};
          ph <= ev_ph; lvl <= ev_lvl; idx <= '0;
          if (ev_fin) begin st <= S_IDLE; done <= 1'b1; status <= ev_code; end
          else if (ev_go) st <= S_TX;
          else st <= S_IDLE;
        end
      endcase
    end
  end
endmodule

module anticoll_select_chk #(
  parameter int TIMEOUT_CYC = 2048
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        tx_valid,
  input logic [7:0]  tx_byte,
  input logic        tx_last,
  input logic [2:0]  tx_bits,
  input logic        tx_crc,
  input logic        rx_valid,
  input logic        done,
  input logic [2:0]  status,
  input logic [3:0]  uid_len,
  input logic [7:0]  sak
);
  localparam int CW = $clog2(TIMEOUT_CYC + 4);
  logic [CW-1:0] quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) quiet <= '0;
    else if (busy && !tx_valid && !rx_valid) quiet <= quiet + 1'b1;
    else quiet <= '0;
  end

  assert_short_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_bits == 3'd7) |-> (tx_last && !tx_crc && (tx_byte == 8'h26 || tx_byte == 8'h52)));
  assert_ac_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_crc && tx_bits == 3'd0 && !tx_last) |->
      (tx_byte == 8'h93 || tx_byte == 8'h95 || tx_byte == 8'h97));
  assert_ok_complete_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 3'd0) |-> !sak[2]);
  assert_uid_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 3'd0) |-> (uid_len == 4'd4 || uid_len == 4'd7 || uid_len == 4'd10));
  assert_wait_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(quiet) <= TIMEOUT_CYC + 1);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_status_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status <= 3'd5));
endmodule

bind anticoll_select anticoll_select_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .tx_valid(tx_valid), .tx_byte(tx_byte),
  .tx_last(tx_last), .tx_bits(tx_bits), .tx_crc(tx_crc), .rx_valid(rx_valid),
  .done(done), .status(status), .uid_len(uid_len), .sak(sak));

// File: tb/anticoll_select_test.sv
`timescale 1ns/1ps
module anticoll_select_test;
  localparam int TMO = 50;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wakeup = 1'b0, halt_after = 1'b0;
  logic busy, tx_valid, tx_last, tx_crc, done;
  logic [7:0] tx_byte, sak;
  logic [2:0] tx_bits, status;
  logic rx_valid = 1'b0, rx_last = 1'b0, rx_coll = 1'b0, rx_crc_ok = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [79:0] uid;
  logic [3:0] uid_len;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  anticoll_select #(.TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .wakeup(wakeup), .halt_after(halt_after),
    .busy(busy), .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_last(tx_last),
    .tx_bits(tx_bits), .tx_crc(tx_crc), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_last(rx_last), .rx_coll(rx_coll), .rx_crc_ok(rx_crc_ok), .done(done),
    .status(status), .uid(uid), .uid_len(uid_len), .sak(sak));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [79:0] got, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  function automatic logic [7:0] xor4(input logic [31:0] b);
    return b[7:0] ^ b[15:8] ^ b[23:16] ^ b[31:24];
  endfunction

  task automatic pulse_start(input bit wk, input bit hl);
    wakeup = wk; halt_after = hl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic expect_frame(input logic [55:0] exp, input int n, input logic [2:0] bits,
                              input bit crc, input string req);
    logic [55:0] got = '0;
    logic [2:0] gb = '0;
    logic gc = 1'b0, lastb = 1'b0;
    int cnt = 0, guard = 0;
    while (!tx_valid && guard < 1000) begin @(negedge clk); guard++; end
    while (tx_valid && cnt < 7 && !lastb) begin
      got[8*cnt +: 8] = tx_byte; gb = tx_bits; gc = tx_crc; lastb = tx_last;
      cnt++;
      @(negedge clk);
    end
    check(got == exp && cnt == n && gb == bits && gc == crc && lastb, req, "frame",
          {24'd0, got}, {24'd0, exp});
  endtask

  task automatic send_resp(input logic [39:0] d, input int n, input bit coll, input bit crcok);
    repeat (2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_byte = d[8*i +: 8]; rx_last = (i == n - 1);
      rx_coll = coll; rx_crc_ok = crcok;
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_last = 1'b0; rx_coll = 1'b0; rx_crc_ok = 1'b0;
  endtask

  task automatic wait_done(input logic [2:0] exp, input string req);
    int guard = 0;
    while (!done && guard < 2000) begin @(negedge clk); guard++; end
    check(done === 1'b1 && status == exp, req, "status", {77'd0, status}, {77'd0, exp});
    @(negedge clk);
    check(!done && !busy, "R11", "pulse", {78'd0, done, busy}, 80'd0);
  endtask

  task automatic request(input bit wk, input bit hl);
    pulse_start(wk, hl);
    expect_frame({48'd0, wk ? 8'h52 : 8'h26}, 1, 3'd7, 1'b0, "R2");
    send_resp({24'd0, 16'h0044}, 2, 1'b0, 1'b0);
  endtask

  task automatic run_level(input int lv, input logic [31:0] b, input logic [7:0] s);
    logic [7:0] sc;
    sc = 8'h93 + 8'(2 * lv);
    expect_frame({40'd0, 8'h20, sc}, 2, 3'd0, 1'b0, "R4");
    send_resp({xor4(b), b}, 5, 1'b0, 1'b0);
    expect_frame({xor4(b), b, 8'h70, sc}, 7, 3'd0, 1'b1, "R6");
    send_resp({32'd0, s}, 1, 1'b0, 1'b1);
  endtask

  task automatic t_reset;
    check(!busy && !tx_valid && !done && uid == 0 && uid_len == 0 && sak == 0, "R1", "reset",
          {73'd0, busy, tx_valid, done, uid_len}, 80'd0);
  endtask

  task automatic t_single;
    bit quiet = 1'b1;
    pulse_start(1'b0, 1'b0);
    expect_frame({48'd0, 8'h26}, 1, 3'd7, 1'b0, "R2");
    pulse_start(1'b1, 1'b1);
    repeat (3) begin if (tx_valid) quiet = 1'b0; @(negedge clk); end
    check(quiet && busy, "R2", "start while busy ignored", {79'd0, quiet}, 80'd1);
    send_resp({24'd0, 16'h0044}, 2, 1'b1, 1'b0);
    run_level(0, 32'h44332211, 8'h08);
    wait_done(3'd0, "R3");
    check(uid == 80'h44332211 && uid_len == 4 && sak == 8'h08, "R8", "single uid",
          uid, 80'h44332211);
  endtask

  task automatic t_double_halt;
    logic [31:0] a = 32'hA3A2A188, b = 32'hB3B2B1B0;
    request(1'b1, 1'b1);
    run_level(0, a, 8'h24);
    run_level(1, b, 8'h20);
    expect_frame({40'd0, 16'h0050}, 2, 3'd0, 1'b1, "R9");
    wait_done(3'd0, "R9");
    check(uid == {24'd0, b, a[31:8]} && uid_len == 7 && sak == 8'h20, "R8", "double uid",
          uid, {24'd0, b, a[31:8]});
  endtask

  task automatic t_triple;
    logic [31:0] a = 32'h0302_0188, b = 32'h1312_1188, c = 32'h2322_2120;
    request(1'b0, 1'b0);
    run_level(0, a, 8'h04);
    run_level(1, b, 8'h04);
    run_level(2, c, 8'h00);
    wait_done(3'd0, "R7");
    check(uid == {c, b[31:8], a[31:8]} && uid_len == 10, "R8", "triple uid",
          uid, {c, b[31:8], a[31:8]});
  endtask

  task automatic t_bad_bcc;
    request(1'b0, 1'b0);
    expect_frame({40'd0, 16'h2093}, 2, 3'd0, 1'b0, "R4");
    send_resp({8'h5A, 32'h04030201}, 5, 1'b0, 1'b0);
    wait_done(3'd1, "R5");
  endtask

  task automatic t_collision;
    request(1'b0, 1'b0);
    expect_frame({40'd0, 16'h2093}, 2, 3'd0, 1'b0, "R4");
    send_resp({8'h04, 32'h04030201}, 5, 1'b1, 1'b0);
    wait_done(3'd2, "R4");
  endtask

  task automatic t_long_atqa;
    pulse_start(1'b0, 1'b0);
    expect_frame({48'd0, 8'h26}, 1, 3'd7, 1'b0, "R2");
    send_resp({16'd0, 24'h000044}, 3, 1'b0, 1'b0);
    wait_done(3'd1, "R3");
  endtask

  task automatic t_timeout;
    pulse_start(1'b1, 1'b0);
    expect_frame({48'd0, 8'h52}, 1, 3'd7, 1'b0, "R2");
    wait_done(3'd3, "R10");
  endtask

  task automatic t_bad_crc;
    logic [31:0] b = 32'h0D0C0B0A;
    request(1'b0, 1'b0);
    expect_frame({40'd0, 16'h2093}, 2, 3'd0, 1'b0, "R4");
    send_resp({xor4(b), b}, 5, 1'b0, 1'b0);
    expect_frame({xor4(b), b, 16'h7093}, 7, 3'd0, 1'b1, "R6");
    send_resp({32'd0, 8'h08}, 1, 1'b0, 1'b0);
    wait_done(3'd4, "R6");
  endtask

  task automatic t_missing_tag;
    request(1'b0, 1'b0);
    run_level(0, 32'h33221112, 8'h04);
    wait_done(3'd1, "R7");
  endtask

  task automatic t_third_incomplete;
    request(1'b0, 1'b0);
    run_level(0, 32'h01020388, 8'h04);
    run_level(1, 32'h05060788, 8'h04);
    run_level(2, 32'h090A0B88, 8'h04);
    wait_done(3'd1, "R7");
  endtask

  task automatic t_halt_nak;
    request(1'b0, 1'b1);
    run_level(0, 32'h44332211, 8'h08);
    expect_frame({40'd0, 16'h0050}, 2, 3'd0, 1'b1, "R9");
    send_resp({32'd0, 8'h0A}, 1, 1'b0, 1'b1);
    wait_done(3'd5, "R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_double_halt();
    t_triple();
    t_bad_bcc();
    t_collision();
    t_long_atqa();
    t_timeout();
    t_bad_crc();
    t_missing_tag();
    t_third_incomplete();
    t_halt_nak();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule